// File: doc/BRIEF.md
# CSR Read-Modify-Write Access Unit

This unit carries out the six control-register access operations: swap, bit-set and bit-clear, each with a register source or a 5-bit immediate source. It sits between the instruction execution stage and an external control-register file. The external file decodes addresses, checks privilege and holds the registers. For each request the unit drives a read strobe, a write strobe, a write mask and write data toward that file, all in the same cycle. Because the two strobes are separate, the file can skip read or write side effects exactly when the operation calls for it.

All three operations reduce to one masked write. The register file applies `new = (old & ~mask) | (data & mask)`. A write or a read is dropped based on the register *indices* of the instruction, never on the data values. The old register value is sampled in the request cycle and returned one cycle later, together with a destination-update strobe. An illegal-access flag from the register file blocks both the write and the destination update.

Top module: `csr_rmw_unit`

## Requirements
- R1: While reset is held, and after it is released, `rsp_valid` and `rsp_rd_we` are 0 until a request has been accepted.
- R2: Operation code `op[1:0]` selects the kind: 01 swap, 10 set, 11 clear. `op[2]`=1 selects the immediate source. Codes 000 and 100 are reserved: they assert neither strobe and never update the destination.
- R3: For swap, `csr_wr_en`=1 and `csr_rd_en`=1 only when `req_rd`≠0. With `req_rd`=0 the register is written but not read.
- R4: For set and clear, `csr_rd_en`=1. `csr_wr_en`=1 only when `req_src_idx`≠0. A nonzero index whose register holds zero still produces a write, with mask 0.
- R5: Swap drives `csr_wr_data` = source and `csr_wr_mask` = all ones.
- R6: Set drives data all ones with mask = source. Clear drives data all zeros with mask = source.
- R7: The immediate forms use `req_src_idx` zero-extended to XLEN as the source, and ignore `req_src_val`.
- R8: One cycle after each accepted request, `rsp_valid` pulses for one cycle. In that same cycle, `rsp_rd_value` holds the `csr_rd_data` seen in the request cycle. `rsp_rd_we` is 1 only if the register was read, `req_rd`≠0 and the access was legal.
- R9: When `csr_illegal`=1 in the request cycle, `csr_wr_en`=0 and `rsp_rd_we`=0, and `rsp_valid` still pulses.
- R10: When `req_narrow`=1, every write mask is limited to bits 31:0, so the upper register bits keep their value.
- R11: With `req_valid`=0 both strobes are 0, and `rsp_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_op | input | 3 | Operation code (see R2) |
| req_rd | input | 5 | Destination register index |
| req_src_idx | input | 5 | Source register index or immediate |
| req_src_val | input | XLEN | Source register value |
| req_narrow | input | 1 | 32-bit execution mode |
| csr_rd_en | output | 1 | Read strobe to register file |
| csr_wr_en | output | 1 | Write strobe to register file |
| csr_wr_mask | output | XLEN | Bits to be updated |
| csr_wr_data | output | XLEN | Value for masked bits |
| csr_rd_data | input | XLEN | Current register value |
| csr_illegal | input | 1 | Access refused by register file |
| rsp_valid | output | 1 | Operation finished |
| rsp_rd_we | output | 1 | Destination update strobe |
| rsp_rd_idx | output | 5 | Destination index |
| rsp_rd_value | output | XLEN | Old register value |

## Verification
The strobes, mask and data toward the register file are combinational in the request cycle. The bench therefore samples them 1 ns after driving the request, well before the capturing edge. The register contents and every `rsp_*` field are due exactly one edge later, and the bench reads them on the falling edge that follows that edge. A behavioural register in the bench applies the masked write at that same edge, so the register value it holds there is the expected result. A final idle cycle confirms that the response pulse lasts only one cycle.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'b00,
      KIND_SWAP  = 2'b01,
      KIND_SET   = 2'b10,
      KIND_CLEAR = 2'b11
   } rmw_kind_t;

   localparam logic [2:0] OP_SWAP   = 3'b001;
   localparam logic [2:0] OP_SET    = 3'b010;
   localparam logic [2:0] OP_CLEAR  = 3'b011;
   localparam logic [2:0] OP_SWAPI  = 3'b101;
   localparam logic [2:0] OP_SETI   = 3'b110;
   localparam logic [2:0] OP_CLEARI = 3'b111;

   localparam int NARROW_W = 32;

   function automatic logic is_bit_op(input logic [2:0] op);
      return (op[1:0] == 2'b10) || (op[1:0] == 2'b11);
   endfunction

endpackage

// File: rtl/csr_rmw_decode.sv
module csr_rmw_decode
   import csr_rmw_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic             valid,
   input  logic [2:0]       op,
   input  logic [IDX_W-1:0] rd,
   input  logic [IDX_W-1:0] src_idx,
   input  logic             illegal,
   output rmw_kind_t        kind,
   output logic             use_imm,
   output logic             rd_en,
   output logic             wr_en,
   output logic             rd_commit
);

   logic rd_nz;
   logic src_nz;

   assign rd_nz   = |rd;
   assign src_nz  = |src_idx;
   assign use_imm = op[2];

   always_comb begin
      unique case (op[1:0])
         2'b01:   kind = KIND_SWAP;
         2'b10:   kind = KIND_SET;
         2'b11:   kind = KIND_CLEAR;
         default: kind = KIND_NONE;
      endcase
   end

   always_comb begin
      rd_en = 1'b0;
      wr_en = 1'b0;
      if (valid) begin
         unique case (kind)
            KIND_SWAP: begin
               rd_en = rd_nz;
               wr_en = !illegal;
            end
            KIND_SET, KIND_CLEAR: begin
               rd_en = 1'b1;
               wr_en = src_nz && !illegal;
            end
            default: begin
               rd_en = 1'b0;
               wr_en = 1'b0;
            end
         endcase
      end
   end

   assign rd_commit = rd_en && rd_nz && !illegal;

endmodule

// File: rtl/csr_rmw_operand.sv
module csr_rmw_operand
   import csr_rmw_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IDX_W = 5
) (
   input  rmw_kind_t         kind,
   input  logic              use_imm,
   input  logic [IDX_W-1:0]  src_idx,
   input  logic [XLEN-1:0]   src_val,
   input  logic              narrow,
   output logic [XLEN-1:0]   wr_mask,
   output logic [XLEN-1:0]   wr_data
);

   localparam int PAD_W = XLEN - IDX_W;

   logic [XLEN-1:0] source;
   logic [XLEN-1:0] raw_mask;
   logic [XLEN-1:0] keep;

   assign source = use_imm ? {{PAD_W{1'b0}}, src_idx} : src_val;

   always_comb begin
      unique case (kind)
         KIND_SWAP: begin
            raw_mask = '1;
            wr_data  = source;
         end
         KIND_SET: begin
            raw_mask = source;
            wr_data  = '1;
         end
         KIND_CLEAR: begin
            raw_mask = source;
            wr_data  = '0;
         end
         default: begin
            raw_mask = '0;
            wr_data  = '0;
         end
      endcase
   end

   generate
      if (XLEN > NARROW_W) begin : g_narrow_clamp
         assign keep = {{(XLEN-NARROW_W){~narrow}}, {NARROW_W{1'b1}}};
      end else begin : g_no_clamp
         logic unused_narrow;
         assign unused_narrow = narrow;
         assign keep = '1;
      end
   endgenerate

   assign wr_mask = raw_mask & keep;

endmodule

// File: rtl/csr_rmw_resp.sv
module csr_rmw_resp #(
   parameter int XLEN  = 64,
   parameter int IDX_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              commit,
   input  logic [IDX_W-1:0]  rd,
   input  logic [XLEN-1:0]   old_val,
   output logic              rsp_valid,
   output logic              rsp_we,
   output logic [IDX_W-1:0]  rsp_idx,
   output logic [XLEN-1:0]   rsp_value
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_we    <= 1'b0;
         rsp_idx   <= '0;
         rsp_value <= '0;
      end else begin
         rsp_valid <= valid;
         rsp_we    <= valid && commit;
         if (valid) begin
            rsp_idx   <= rd;
            rsp_value <= old_val;
         end
      end
   end

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
   import csr_rmw_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IDX_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [IDX_W-1:0]  req_rd,
   input  logic [IDX_W-1:0]  req_src_idx,
   input  logic [XLEN-1:0]   req_src_val,
   input  logic              req_narrow,
   output logic              csr_rd_en,
   output logic              csr_wr_en,
   output logic [XLEN-1:0]   csr_wr_mask,
   output logic [XLEN-1:0]   csr_wr_data,
   input  logic [XLEN-1:0]   csr_rd_data,
   input  logic              csr_illegal,
   output logic              rsp_valid,
   output logic              rsp_rd_we,
   output logic [IDX_W-1:0]  rsp_rd_idx,
   output logic [XLEN-1:0]   rsp_rd_value
);

   generate
      if (XLEN < NARROW_W) begin : g_bad_xlen
         $error("csr_rmw_unit: XLEN must be at least 32");
      end
      if (IDX_W < 1 || IDX_W >= XLEN) begin : g_bad_idx
         $error("csr_rmw_unit: IDX_W out of range");
      end
   endgenerate

   rmw_kind_t kind;
   logic      use_imm;
   logic      rd_commit;

   csr_rmw_decode #(.IDX_W(IDX_W)) u_decode (
      .valid     (req_valid),
      .op        (req_op),
      .rd        (req_rd),
      .src_idx   (req_src_idx),
      .illegal   (csr_illegal),
      .kind      (kind),
      .use_imm   (use_imm),
      .rd_en     (csr_rd_en),
      .wr_en     (csr_wr_en),
      .rd_commit (rd_commit)
   );

   csr_rmw_operand #(.XLEN(XLEN), .IDX_W(IDX_W)) u_operand (
      .kind    (kind),
      .use_imm (use_imm),
      .src_idx (req_src_idx),
      .src_val (req_src_val),
      .narrow  (req_narrow),
      .wr_mask (csr_wr_mask),
      .wr_data (csr_wr_data)
   );

   csr_rmw_resp #(.XLEN(XLEN), .IDX_W(IDX_W)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (req_valid),
      .commit    (rd_commit),
      .rd        (req_rd),
      .old_val   (csr_rd_data),
      .rsp_valid (rsp_valid),
      .rsp_we    (rsp_rd_we),
      .rsp_idx   (rsp_rd_idx),
      .rsp_value (rsp_rd_value)
   );

endmodule

// File: rtl/csr_rmw_unit_chk.sv
module csr_rmw_unit_chk
   import csr_rmw_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IDX_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [2:0]        req_op,
   input logic [IDX_W-1:0]  req_rd,
   input logic [IDX_W-1:0]  req_src_idx,
   input logic              req_narrow,
   input logic              csr_rd_en,
   input logic              csr_wr_en,
   input logic [XLEN-1:0]   csr_wr_mask,
   input logic              csr_illegal,
   input logic              rsp_valid,
   input logic              rsp_rd_we,
   input logic [IDX_W-1:0]  rsp_rd_idx
);

   AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!csr_rd_en && !csr_wr_en)); // R11

   AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && csr_illegal) |-> !csr_wr_en); // R9

   AST_ILLEGAL_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && csr_illegal) |=> (rsp_valid && !rsp_rd_we)); // R9

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R8

   AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R11

   AST_COMMIT_NONZERO_RD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_rd_we |-> (rsp_rd_idx != '0)); // R8

   AST_BITOP_ZERO_IDX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_bit_op(req_op) && req_src_idx == '0) |-> !csr_wr_en); // R4

   AST_SWAP_ZERO_RD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op[1:0] == 2'b01 && req_rd == '0) |-> !csr_rd_en); // R3

   generate
      if (XLEN > NARROW_W) begin : g_narrow_chk
         AST_NARROW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_narrow) |-> (csr_wr_mask[XLEN-1:NARROW_W] == '0)); // R10
      end else begin : g_narrow_none
         logic unused_n;
         assign unused_n = req_narrow ^ (|csr_wr_mask);
      end
   endgenerate

endmodule

bind csr_rmw_unit csr_rmw_unit_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_op      (req_op),
   .req_rd      (req_rd),
   .req_src_idx (req_src_idx),
   .req_narrow  (req_narrow),
   .csr_rd_en   (csr_rd_en),
   .csr_wr_en   (csr_wr_en),
   .csr_wr_mask (csr_wr_mask),
   .csr_illegal (csr_illegal),
   .rsp_valid   (rsp_valid),
   .rsp_rd_we   (rsp_rd_we),
   .rsp_rd_idx  (rsp_rd_idx)
);

// File: tb/tb_csr_rmw_unit.sv
`timescale 1ns/1ps
module tb_csr_rmw_unit;

   localparam int XLEN  = 64;
   localparam int IDX_W = 5;
   localparam int NVEC  = 18;

   typedef struct packed {
      logic [2:0]  op;
      logic [4:0]  rd;
      logic [4:0]  idx;
      logic [63:0] val;
      logic        narrow;
      logic        illegal;
      logic [63:0] init;
      logic        exp_rd_en;
      logic        exp_wr_en;
      logic [63:0] exp_new;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      // R3 R5 swap, reads and writes
      '{3'b001, 5'd5, 5'd7, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0, 64'hFFFF_0000_FFFF_0000, 1'b1, 1'b1, 64'h1234_5678_9ABC_DEF0},
      // R3 swap to index 0: write only
      '{3'b001, 5'd0, 5'd3, 64'h0000_0000_0000_00A5, 1'b0, 1'b0, 64'h0000_0000_0000_0077, 1'b0, 1'b1, 64'h0000_0000_0000_00A5},
      // R6 set
      '{3'b010, 5'd2, 5'd4, 64'h0000_0000_0000_00F0, 1'b0, 1'b0, 64'h0000_0000_0000_0100, 1'b1, 1'b1, 64'h0000_0000_0000_01F0},
      // R6 clear
      '{3'b011, 5'd9, 5'd6, 64'h0000_0000_0000_00FF, 1'b0, 1'b0, 64'h0000_0000_0000_FFFF, 1'b1, 1'b1, 64'h0000_0000_0000_FF00},
      // R4 set with index 0: read only
      '{3'b010, 5'd1, 5'd0, 64'h0000_0000_0000_FFFF, 1'b0, 1'b0, 64'h0000_0000_0000_0055, 1'b1, 1'b0, 64'h0000_0000_0000_0055},
      // R4 clear with index 0 and rd 0
      '{3'b011, 5'd0, 5'd0, 64'h0000_0000_0000_FFFF, 1'b0, 1'b0, 64'h0000_0000_0000_0055, 1'b1, 1'b0, 64'h0000_0000_0000_0055},
      // R4 nonzero index holding zero still writes
      '{3'b010, 5'd3, 5'd8, 64'h0,                   1'b0, 1'b0, 64'h0000_0000_0000_0042, 1'b1, 1'b1, 64'h0000_0000_0000_0042},
      // R7 swap immediate
      '{3'b101, 5'd4, 5'h1F, 64'h0000_0000_0000_DEAD, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 64'h0000_0000_0000_001F},
      // R7 set immediate
      '{3'b110, 5'd6, 5'h0A, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 64'h0000_0000_0000_0100, 1'b1, 1'b1, 64'h0000_0000_0000_010A},
      // R7 clear immediate
      '{3'b111, 5'd7, 5'h03, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 64'h0000_0000_0000_000F, 1'b1, 1'b1, 64'h0000_0000_0000_000C},
      // R4 R7 set immediate zero: no write
      '{3'b110, 5'd7, 5'h00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 64'h0000_0000_0000_0009, 1'b1, 1'b0, 64'h0000_0000_0000_0009},
      // R10 narrow swap
      '{3'b001, 5'd1, 5'd2, 64'hFFFF_FFFF_1111_2222, 1'b1, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, 1'b1, 64'hAAAA_BBBB_1111_2222},
      // R10 narrow set
      '{3'b010, 5'd1, 5'd2, 64'hFFFF_0000_0000_00F0, 1'b1, 1'b0, 64'h0,                   1'b1, 1'b1, 64'h0000_0000_0000_00F0},
      // R10 narrow clear
      '{3'b011, 5'd1, 5'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 64'hFFFF_FFFF_0000_0000},
      // R9 illegal swap
      '{3'b001, 5'd5, 5'd1, 64'h0000_0000_0000_0001, 1'b0, 1'b1, 64'h0000_0000_0000_0033, 1'b1, 1'b0, 64'h0000_0000_0000_0033},
      // R9 illegal clear
      '{3'b011, 5'd2, 5'd3, 64'h0000_0000_0000_00FF, 1'b0, 1'b1, 64'h0000_0000_0000_00FF, 1'b1, 1'b0, 64'h0000_0000_0000_00FF},
      // R2 reserved code 100
      '{3'b100, 5'd5, 5'd5, 64'h0000_0000_0000_00FF, 1'b0, 1'b0, 64'h0000_0000_0000_0066, 1'b0, 1'b0, 64'h0000_0000_0000_0066},
      // R3 R7 swap immediate zero to rd 0
      '{3'b101, 5'd0, 5'd0, 64'h0000_0000_0000_00FF, 1'b0, 1'b0, 64'h0000_0000_0000_0077, 1'b0, 1'b1, 64'h0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [2:0]        req_op = '0;
   logic [IDX_W-1:0]  req_rd = '0;
   logic [IDX_W-1:0]  req_src_idx = '0;
   logic [XLEN-1:0]   req_src_val = '0;
   logic              req_narrow = 1'b0;
   logic              csr_rd_en;
   logic              csr_wr_en;
   logic [XLEN-1:0]   csr_wr_mask;
   logic [XLEN-1:0]   csr_wr_data;
   logic [XLEN-1:0]   csr_rd_data;
   logic              csr_illegal = 1'b0;
   logic              rsp_valid;
   logic              rsp_rd_we;
   logic [IDX_W-1:0]  rsp_rd_idx;
   logic [XLEN-1:0]   rsp_rd_value;

   // behavioural control register
   logic [XLEN-1:0]   model_reg = '0;
   logic              load_req = 1'b0;
   logic [XLEN-1:0]   load_val = '0;

   int n_run  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   assign csr_rd_data = model_reg;

   always @(posedge clk) begin
      if (load_req)
         model_reg <= load_val;
      else if (csr_wr_en)
         model_reg <= (model_reg & ~csr_wr_mask) | (csr_wr_data & csr_wr_mask);
   end

   csr_rmw_unit #(.XLEN(XLEN), .IDX_W(IDX_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_rd(req_rd), .req_src_idx(req_src_idx), .req_src_val(req_src_val),
      .req_narrow(req_narrow), .csr_rd_en(csr_rd_en), .csr_wr_en(csr_wr_en),
      .csr_wr_mask(csr_wr_mask), .csr_wr_data(csr_wr_data),
      .csr_rd_data(csr_rd_data), .csr_illegal(csr_illegal),
      .rsp_valid(rsp_valid), .rsp_rd_we(rsp_rd_we), .rsp_rd_idx(rsp_rd_idx),
      .rsp_rd_value(rsp_rd_value)
   );

   task automatic chk(input logic ok, input string req, input int tag,
                      input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s (case %0d): actual %h expected %h", req, tag, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic exp_we;
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 0, 64'(rsp_valid), 64'd0);
      chk(rsp_rd_we == 1'b0, "R1 rsp_rd_we in reset", 0, 64'(rsp_rd_we), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 0, 64'(rsp_valid), 64'd0);
      // R11 idle strobes
      #1;
      chk(!csr_rd_en && !csr_wr_en, "R11 idle strobes", 0,
          64'({csr_rd_en, csr_wr_en}), 64'd0);

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         load_req = 1'b1;
         load_val = VECS[i].init;
         @(negedge clk);
         load_req    = 1'b0;
         req_valid   = 1'b1;
         req_op      = VECS[i].op;
         req_rd      = VECS[i].rd;
         req_src_idx = VECS[i].idx;
         req_src_val = VECS[i].val;
         req_narrow  = VECS[i].narrow;
         csr_illegal = VECS[i].illegal;
         #1;
         chk(csr_rd_en == VECS[i].exp_rd_en, "R2 R3 R4 read strobe", i,
             64'(csr_rd_en), 64'(VECS[i].exp_rd_en));
         chk(csr_wr_en == VECS[i].exp_wr_en, "R2 R3 R4 R9 write strobe", i,
             64'(csr_wr_en), 64'(VECS[i].exp_wr_en));
         @(negedge clk);
         req_valid   = 1'b0;
         csr_illegal = 1'b0;
         exp_we = (VECS[i].rd != 5'd0) && VECS[i].exp_rd_en && !VECS[i].illegal;
         chk(rsp_valid == 1'b1, "R8 response pulse", i, 64'(rsp_valid), 64'd1);
         chk(rsp_rd_we == exp_we, "R8 R9 destination strobe", i,
             64'(rsp_rd_we), 64'(exp_we));
         if (exp_we) begin
            chk(rsp_rd_value == VECS[i].init, "R8 old value returned", i,
                rsp_rd_value, VECS[i].init);
            chk(rsp_rd_idx == VECS[i].rd, "R8 destination index", i,
                64'(rsp_rd_idx), 64'(VECS[i].rd));
         end
         chk(model_reg == VECS[i].exp_new, "R5 R6 R7 R10 register result", i,
             model_reg, VECS[i].exp_new);
      end

      // R11 response lasts one cycle only
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R11 no response when idle", 99, 64'(rsp_valid), 64'd0);

      // R5 swap data/mask observed directly
      req_valid = 1'b1; req_op = 3'b001; req_rd = 5'd1; req_src_idx = 5'd2;
      req_src_val = 64'h0F0F_0000_0000_1234; req_narrow = 1'b0;
      #1;
      chk(csr_wr_mask == '1, "R5 swap mask all ones", 100, csr_wr_mask, '1);
      chk(csr_wr_data == 64'h0F0F_0000_0000_1234, "R5 swap data", 100,
          csr_wr_data, 64'h0F0F_0000_0000_1234);
      // R6 clear data zero, mask source
      req_op = 3'b011;
      #1;
      chk(csr_wr_data == '0 && csr_wr_mask == 64'h0F0F_0000_0000_1234,
          "R6 clear data/mask", 101, csr_wr_mask, 64'h0F0F_0000_0000_1234);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule